// File: doc/BRIEF.md
# Hardware cursor overlay

This block lays one small, host-loaded pointer image over the stream of pixels that already combines video and graphics. The image holds 1024 pixels at two bits each. It can be arranged as one of five rectangles with that same area, from wide and flat to tall and narrow. Each two-bit pixel code picks one entry of a four-entry colour table. An entry gives a narrow luma, two narrow chroma components and a two-bit blend weight.

Each clock brings a pixel counter, a line counter and the background Y, U and V. One clock later the block puts out the blended pixel. The host writes the image, the colour table, the placement and the shape through one write port. Placement and shape are held in staging registers and are copied into use on a field-start pulse. The signed placement allows the rectangle to hang partly over any screen edge.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held, out_y, out_u and out_v are zero. After reset, with no further writes, every output pixel equals the background pixel presented one clock earlier.
- R2: A write to wr_addr 0..127 stores 16 image bits as eight pixels. Pixel index 8·wr_addr + j takes wr_data[2j+1:2j].
- R3: A write of wr_data[2:0] to wr_addr 0x86 stages a shape. Codes 0 to 4 give widths 8, 16, 32, 64 and 128, and the height is 1024 divided by the width. Codes 5 to 7 are ignored and leave the staged shape as it was.
- R4: Let dx = pixel − x0 and dy = line − y0. The cursor covers a pixel when dx is from 0 to width−1 and dy is from 0 to height−1. A covered pixel reads image index dy·width + dx. Every uncovered pixel passes the background unchanged.
- R5: A write to wr_addr 0x80+k stores colour entry k. The fields are Y at wr_data[15:10], U at [9:6], V at [5:2] and T at [1:0]. Y is widened to 8 bits as {Y,00}, and U and V as {U,0000} and {V,0000}.
- R6: For a covered pixel, each output component equals floor((bg·(3−T) + c·T)/3). Here c is the widened entry component and T is the entry's weight. T=0 returns the background and T=3 returns the entry colour.
- R7: Writes to 0x84 (x0), 0x85 (y0) and 0x86 (shape) take effect on the clock where field_start is high, and not before.
- R8: x0 is a signed 12-bit value from wr_data[11:0] and y0 is a signed 11-bit value from wr_data[10:0]. Negative values, or values close to the right or bottom edge, clip the rectangle and never wrap it.
- R9: The output for a pixel appears on the clock after its inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low synchronous reset |
| field_start | input | 1 | one-clock pulse that copies the staged placement and shape into use |
| pix_x | input | 11 | pixel counter within the line |
| pix_y | input | 10 | line counter within the field |
| bg_y | input | 8 | background luma |
| bg_u | input | 8 | background U |
| bg_v | input | 8 | background V |
| wr_en | input | 1 | host write strobe |
| wr_addr | input | 8 | host write address |
| wr_data | input | 16 | host write data |
| out_y | output | 8 | blended luma |
| out_u | output | 8 | blended U |
| out_v | output | 8 | blended V |

## Verification
The assertions assume that pix_x, pix_y and the background components are known on every clock after reset. They also assume that a host write and a field_start pulse can fall on any clock, with no ordering between them. The stimulus follows these assumptions. Every pixel is driven with fully defined random or directed values. Writes come in between pixels, and field starts are issued on their own clocks. Placement is drawn both inside the screen and past each edge, so the clipping checks see the rectangle both whole and cut off.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int XW    = 11,
  parameter int YW    = 10,
  parameter int CW    = 8,
  parameter int NPIX  = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  logic [CW-1:0] bg_y,
  input  logic [CW-1:0] bg_u,
  input  logic [CW-1:0] bg_v,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [15:0]   wr_data,
  output logic [CW-1:0] out_y,
  output logic [CW-1:0] out_u,
  output logic [CW-1:0] out_v
);
  localparam int AW    = $clog2(NPIX);
  localparam int WORDS = NPIX / 8;
  localparam int PXW   = XW + 1;
  localparam int PYW   = YW + 1;

  logic [15:0] bitmap [WORDS];
  logic [15:0] clut   [4];
  logic signed [PXW-1:0] x0_pend, x0_act;
  logic signed [PYW-1:0] y0_pend, y0_act;
  logic [2:0] sh_pend, sh_act;

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr < 8'(WORDS)) bitmap[wr_addr[AW-4:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) clut[i] <= '0;
      x0_pend <= '0; y0_pend <= '0; sh_pend <= '0;
      x0_act  <= '0; y0_act  <= '0; sh_act  <= '0;
    end else begin
      if (wr_en) begin
        if (wr_addr[7:2] == 6'b100000) clut[wr_addr[1:0]] <= wr_data;
        if (wr_addr == 8'h84) x0_pend <= wr_data[PXW-1:0];
        if (wr_addr == 8'h85) y0_pend <= wr_data[PYW-1:0];
        if (wr_addr == 8'h86 && wr_data[2:0] <= 3'd4) sh_pend <= wr_data[2:0];
      end
      if (field_start) begin
        x0_act <= x0_pend;
        y0_act <= y0_pend;
        sh_act <= sh_pend;
      end
    end
  end

  logic signed [PXW+1:0] dx;
  logic signed [PYW+1:0] dy;
  logic [8:0] width, height;
  logic       hit;
  logic [AW-1:0] addr;
  logic [15:0] word, ent;
  logic [1:0]  code, t;
  logic [CW-1:0] cy, cu, cv;

  assign dx     = $signed({3'b000, pix_x}) - PXW'(x0_act);
  assign dy     = $signed({3'b000, pix_y}) - PYW'(y0_act);
  assign width  = 9'd8 << sh_act;
  assign height = 9'd128 >> sh_act;
  assign hit    = (dx >= 0) && (dx < $signed({5'b0, width})) &&
                  (dy >= 0) && (dy < $signed({4'b0, height}));
  assign addr   = (AW'(dy[6:0]) << (3 + sh_act)) | AW'(dx[6:0]);
  assign word   = bitmap[addr[AW-1:3]];
  assign code   = word[{addr[2:0], 1'b0} +: 2];
  assign ent    = clut[code];
  assign t      = ent[1:0];
  assign cy     = {ent[15:10], 2'b00};
  assign cu     = {ent[9:6], 4'b0000};
  assign cv     = {ent[5:2], 4'b0000};

  function automatic logic [CW-1:0] blend(input logic [CW-1:0] b, input logic [CW-1:0] c,
                                          input logic [1:0] w);
    logic [CW+1:0] s;
    s = b * (CW+2)'(3 - w) + c * (CW+2)'(w);
    return CW'(s / 3);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_y <= '0; out_u <= '0; out_v <= '0;
    end else if (hit) begin
      out_y <= blend(bg_y, cy, t);
      out_u <= blend(bg_u, cu, t);
      out_v <= blend(bg_v, cv, t);
    end else begin
      out_y <= bg_y; out_u <= bg_u; out_v <= bg_v;
    end
  end

  // R4
  pass_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (out_y == $past(bg_y) && out_u == $past(bg_u) && out_v == $past(bg_v)));

  // R6
  opaque_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && t == 2'd3) |=> (out_y == $past(cy) && out_u == $past(cu) && out_v == $past(cv)));

  // R6
  blend_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ((out_y >= $past(bg_y) || out_y >= $past(cy)) &&
             (out_y <= $past(bg_y) || out_y <= $past(cy))));

  // R7
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> ($stable(x0_act) && $stable(y0_act) && $stable(sh_act)));

  // R3
  bad_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h86 && wr_data[2:0] > 3'd4) |=> $stable(sh_pend));

  // R3
  shape_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_act <= 3'd4);
endmodule

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb_top;
  logic clk = 0, rst_n = 0, field_start = 0, wr_en = 0;
  logic [10:0] pix_x = 0;
  logic [9:0]  pix_y = 0;
  logic [7:0]  bg_y = 0, bg_u = 0, bg_v = 0, wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [7:0]  out_y, out_u, out_v;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cursor_overlay dut_i (.clk, .rst_n, .field_start, .pix_x, .pix_y, .bg_y, .bg_u, .bg_v,
                        .wr_en, .wr_addr, .wr_data, .out_y, .out_u, .out_v);

  logic [1:0]  m_bm [1024];
  logic [15:0] m_clut [4];
  int m_xp, m_yp, m_sp, m_xa, m_ya, m_sa;

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mix(logic [7:0] b, logic [7:0] c, int w);
    return 8'((int'(b) * (3 - w) + int'(c) * w) / 3);
  endfunction

  function automatic logic [23:0] model(int x, int y, logic [7:0] by, logic [7:0] bu, logic [7:0] bv);
    int w, h, dx, dy, w8;
    logic [15:0] e;
    w = 8 << m_sa; h = 1024 / w;
    dx = x - m_xa; dy = y - m_ya;
    if (dx < 0 || dx >= w || dy < 0 || dy >= h) return {by, bu, bv};
    e = m_clut[m_bm[dy * w + dx]];
    w8 = int'(e[1:0]);
    return {mix(by, {e[15:10], 2'b00}, w8), mix(bu, {e[9:6], 4'h0}, w8), mix(bv, {e[5:2], 4'h0}, w8)};
  endfunction

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a < 128) for (int j = 0; j < 8; j++) m_bm[a * 8 + j] = d[2*j +: 2];
    else if (a[7:2] == 6'b100000) m_clut[a[1:0]] = d;
    else if (a == 8'h84) m_xp = int'($signed(d[11:0]));
    else if (a == 8'h85) m_yp = int'($signed(d[10:0]));
    else if (a == 8'h86 && d[2:0] <= 4) m_sp = int'(d[2:0]);
  endtask

  task automatic fs();
    @(negedge clk);
    field_start = 1;
    @(negedge clk);
    field_start = 0;
    m_xa = m_xp; m_ya = m_yp; m_sa = m_sp;
  endtask

  task automatic px(string req, int x, int y, logic [7:0] by, logic [7:0] bu, logic [7:0] bv);
    logic [23:0] e;
    @(negedge clk);
    pix_x = 11'(x); pix_y = 10'(y); bg_y = by; bg_u = bu; bg_v = bv;
    e = model(x, y, by, bu, bv);
    @(posedge clk); #1;
    chk(req, {out_y, out_u, out_v}, e);
  endtask

  task automatic rpx(string req, int x, int y);
    px(req, x, y, 8'($urandom), 8'($urandom), 8'($urandom));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) m_bm[i] = 0;
    for (int i = 0; i < 4; i++) m_clut[i] = 0;
    m_xp = 0; m_yp = 0; m_sp = 0; m_xa = 0; m_ya = 0; m_sa = 0;
    bg_y = 8'hAA; bg_u = 8'h55; bg_v = 8'h33;
    repeat (3) @(posedge clk); #1;
    chk("R1 reset", {out_y, out_u, out_v}, 24'h0);
    @(negedge clk); rst_n = 1;
    // R1 after reset all pass through
    for (int i = 0; i < 6; i++) rpx("R1", i, i);
    // R2 bitmap load, R5 colour table
    for (int k = 0; k < 128; k++) wr(8'(k), 16'($urandom));
    wr(8'h80, 16'h0000);
    wr(8'h81, {6'h3F, 4'hF, 4'h0, 2'd3});
    wr(8'h82, {6'h10, 4'h8, 4'h4, 2'd1});
    wr(8'h83, {6'h25, 4'h3, 4'hC, 2'd2});
    // R7 staged position not yet active
    wr(8'h84, 16'd100); wr(8'h85, 16'd50); wr(8'h86, 16'd2);
    rpx("R7 before field", 100, 50);
    rpx("R7 before field", 5, 5);
    fs();
    // R4 R2 R5 R6 whole rectangle scan for 32x32
    for (int y = 49; y <= 82; y++)
      for (int x = 99; x <= 132; x++) rpx("R4", x, y);
    // R6 directed extremes
    wr(8'h0, 16'h5555);
    px("R6 opaque", 100, 50, 8'h00, 8'h00, 8'h00);
    px("R6 opaque", 101, 50, 8'hFF, 8'hFF, 8'hFF);
    wr(8'h0, 16'hAAAA);
    px("R6 third", 100, 50, 8'hFF, 8'h00, 8'h80);
    wr(8'h0, 16'hFFFF);
    px("R6 two thirds", 100, 50, 8'h01, 8'hFE, 8'h7F);
    // R3 each shape, then illegal codes ignored
    for (int s = 0; s < 5; s++) begin
      wr(8'h86, 16'(s)); fs();
      for (int i = 0; i < 300; i++)
        rpx("R3", 100 + int'($urandom_range(0, 140)) - 4, 50 + int'($urandom_range(0, 140)) - 4);
    end
    wr(8'h86, 16'd1); wr(8'h86, 16'd6); wr(8'h86, 16'd7); wr(8'h86, 16'd5); fs();
    rpx("R3 ignored code", 115, 50); rpx("R3 ignored code", 116, 50);
    rpx("R3 ignored code", 100, 113); rpx("R3 ignored code", 100, 114);
    // R8 negative and edge positions
    for (int r = 0; r < 8; r++) begin
      int xs, ys;
      xs = (r % 2) ? -int'($urandom_range(1, 120)) : 1900 + int'($urandom_range(0, 140));
      ys = (r < 4) ? -int'($urandom_range(1, 120)) : 960 + int'($urandom_range(0, 60));
      wr(8'h84, 16'(xs)); wr(8'h85, 16'(ys)); wr(8'h86, 16'($urandom_range(0, 4))); fs();
      for (int i = 0; i < 200; i++)
        rpx("R8 clip", (xs < 0) ? int'($urandom_range(0, 130)) : int'($urandom_range(1890, 2047)),
                       (ys < 0) ? int'($urandom_range(0, 130)) : int'($urandom_range(950, 1023)));
    end
    // R9 output one clock later: inputs change each clock, check per cycle
    wr(8'h84, 16'd0); wr(8'h85, 16'd0); wr(8'h86, 16'd4); fs();
    for (int x = 0; x < 140; x++) rpx("R9", x, 3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule